// File: doc/BRIEF.md
# Reset-Time Boot Mode Selector

This block decides, right after reset is let go, whether the controller comes up in a serial debug monitor mode or in normal user mode. After a power-on reset it fetches the two reset-vector bytes through a one-cycle-latency memory read port and tests whether both are erased. At the same point it samples a synchronized over-voltage flag from the interrupt pin and the level of a strap pin. From these three facts it latches the mode and the bus-clock divide ratio.

It drives a watchdog disable, a monitor serial-link enable and a divide-ratio flag. It also produces the bus clock itself, as a one-cycle clock-enable pulse taken from the oscillator-rate clock.

The decision belongs to the power-on reset alone. A warm reset keeps the stored decision: after it the block reports the same mode again without touching memory. The watchdog disable is not frozen. On the over-voltage path it follows the live over-voltage level on the interrupt pin or on the reset pin.

Top module: `boot_mode_sel`

## Requirements
- R1: After a power-on reset is released, the block reads address 0xFFFE and then 0xFFFF, on consecutive cycles, with `mem_rd_en` high for each read. `mode_valid` rises on the 4th rising edge after release, and `mem_rd_en` is low whenever `mode_valid` is high.
- R2: Over-voltage flag set and strap low gives monitor mode with `div_half`=1, where 1 means the bus runs at the oscillator rate divided by 2.
- R3: Over-voltage flag set and strap high gives monitor mode with `div_half`=0, where 0 means divide by 4.
- R4: Over-voltage flag clear and both vector bytes equal to 0xFF gives monitor mode with `div_half`=0, whatever the strap level.
- R5: Over-voltage flag clear and either vector byte other than 0xFF gives user mode (`monitor_mode`=0) with `div_half`=0.
- R6: In monitor mode `mon_serial_en` is 1. In user mode both `mon_serial_en` and `wdog_disable` are 0. On the erased-vector path `wdog_disable` is held at 1.
- R7: On the over-voltage path, `wdog_disable` equals the OR of the two over-voltage inputs, after a delay of at most 3 cycles. The mode itself stays monitor.
- R8: `bus_ce` is a single-cycle pulse, once every 2 cycles when `div_half`=1 and once every 4 cycles when `div_half`=0.
- R9: While `mode_valid` is high, `monitor_mode` and `div_half` do not change, even when the strap or the over-voltage inputs change.
- R10: A warm reset (`rst` without `por`) issues no memory reads. `mode_valid` returns on the 1st edge after release, with the previously latched mode, and the strap and vector contents are ignored. A later `por` evaluates the mode again.
- R11: During reset, `mode_valid`, `monitor_mode`, `div_half`, `wdog_disable`, `mon_serial_en`, `mem_rd_en` and `bus_ce` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous warm reset, active high |
| por | input | 1 | Synchronous power-on reset, active high; also clears the stored decision |
| irq_hv_raw | input | 1 | Asynchronous over-voltage flag on the interrupt pin |
| rst_hv_raw | input | 1 | Asynchronous over-voltage flag on the reset pin |
| strap_raw | input | 1 | Asynchronous strap pin level |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the request |
| mode_valid | output | 1 | Mode decision is valid |
| monitor_mode | output | 1 | 1 = monitor mode, 0 = user mode |
| div_half | output | 1 | 1 = bus is clock/2, 0 = bus is clock/4 |
| bus_ce | output | 1 | Bus clock-enable pulse |
| wdog_disable | output | 1 | Watchdog disable |
| mon_serial_en | output | 1 | Monitor serial-link enable |

## Verification
The bench uses the default parameters: a 16-bit address, so the vector sits at 0xFFFE/0xFFFF, divide ratios of 2 and 4, and two synchronizer stages. With these values the evaluation takes four edges and the clock-enable periods are only 2 or 4 cycles. That makes it practical to check read order, decision latency and pulse spacing at the exact cycle. The two-stage synchronizers put a 3-cycle bound on how fast the watchdog disable follows the over-voltage inputs, and the bench probes that bound after each input change.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RD_LO = 3'd1,
    S_RD_HI = 3'd2,
    S_CMP   = 3'd3,
    S_DONE  = 3'd4
  } bm_state_t;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bm_ce_div.sv
module bm_ce_div #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic half,
  output logic ce
);
  localparam int CW = $clog2(DIV_SLOW);
  localparam logic [CW-1:0] FAST_M1 = CW'(DIV_FAST - 1);
  localparam logic [CW-1:0] SLOW_M1 = CW'(DIV_SLOW - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = half ? FAST_M1 : SLOW_M1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ce  <= 1'b0;
    end else if (cnt >= lim) begin
      cnt <= '0;
      ce  <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      ce  <= 1'b0;
    end
  end

  // R8: a pulse never lasts two cycles
  p_ce_single_r8: assert property (@(posedge clk) disable iff (rst)
    ce |=> !ce);
endmodule

// File: rtl/bm_eval.sv
module bm_eval
  import boot_mode_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              por,
  input  logic              irq_hv,
  input  logic              rst_hv,
  input  logic              strap,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mode_valid,
  output logic              monitor_mode,
  output logic              div_half,
  output logic              wdog_disable,
  output logic              mon_serial_en
);
  localparam logic [ADDR_W-1:0] VEC_HI = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] VEC_LO = VEC_HI - 1'b1;
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  bm_state_t state;
  logic lo_blank;
  logic evaluated, dec_mon, dec_half, dec_hvpath;
  logic fresh_mon, fresh_half;
  logic nxt_mon, nxt_half, nxt_hvpath, enter;

  assign fresh_mon  = irq_hv | (lo_blank & (mem_rd_data == ERASED));
  assign fresh_half = irq_hv & ~strap;
  assign nxt_mon    = (state == S_CMP) ? fresh_mon  : dec_mon;
  assign nxt_half   = (state == S_CMP) ? fresh_half : dec_half;
  assign nxt_hvpath = (state == S_CMP) ? irq_hv     : dec_hvpath;
  assign enter      = (state == S_CMP) || ((state == S_IDLE) && evaluated);

  // sequencer: two vector reads, then compare
  always_ff @(posedge clk) begin
    if (rst_any) begin
      state      <= S_IDLE;
      mem_rd_en  <= 1'b0;
      mem_addr   <= VEC_LO;
      lo_blank   <= 1'b0;
      mode_valid <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (evaluated) begin
            state      <= S_DONE;
            mode_valid <= 1'b1;
          end else begin
            mem_rd_en <= 1'b1;
            mem_addr  <= VEC_LO;
            state     <= S_RD_LO;
          end
        end
        S_RD_LO: begin
          mem_addr <= VEC_HI;
          state    <= S_RD_HI;
        end
        S_RD_HI: begin
          lo_blank  <= (mem_rd_data == ERASED);
          mem_rd_en <= 1'b0;
          state     <= S_CMP;
        end
        S_CMP: begin
          state      <= S_DONE;
          mode_valid <= 1'b1;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  // stored decision: survives warm reset, cleared by power-on reset
  always_ff @(posedge clk) begin
    if (por) begin
      evaluated  <= 1'b0;
      dec_mon    <= 1'b0;
      dec_half   <= 1'b0;
      dec_hvpath <= 1'b0;
    end else if (!rst_any && state == S_CMP) begin
      evaluated  <= 1'b1;
      dec_mon    <= fresh_mon;
      dec_half   <= fresh_half;
      dec_hvpath <= irq_hv;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst_any) begin
      monitor_mode  <= 1'b0;
      div_half      <= 1'b0;
      mon_serial_en <= 1'b0;
      wdog_disable  <= 1'b0;
    end else begin
      if (enter) begin
        monitor_mode  <= nxt_mon;
        div_half      <= nxt_half;
        mon_serial_en <= nxt_mon;
      end
      wdog_disable <= (enter | mode_valid) & nxt_mon &
                      (~nxt_hvpath | irq_hv | rst_hv);
    end
  end

  // R1: no read is outstanding once the decision is valid
  p_no_read_after_valid_r1: assert property (@(posedge clk) disable iff (rst_any)
    mode_valid |-> !mem_rd_en);
  // R1: reads only target the vector bytes
  p_read_vector_r1: assert property (@(posedge clk) disable iff (rst_any)
    mem_rd_en |-> (mem_addr[ADDR_W-1:1] == VEC_HI[ADDR_W-1:1]));
  // R2: the fast ratio exists only in monitor mode
  p_fast_is_monitor_r2: assert property (@(posedge clk) disable iff (rst_any)
    div_half |-> monitor_mode);
  // R6: user mode never disables the watchdog
  p_user_wdog_r6: assert property (@(posedge clk) disable iff (rst_any)
    (mode_valid && !monitor_mode) |-> !wdog_disable);
  // R9: decision held while valid
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst_any)
    (mode_valid && $past(mode_valid)) |-> ($stable(div_half) && $stable(monitor_mode)));
endmodule

// File: rtl/boot_mode_sel.sv
module boot_mode_sel #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_FAST    = 2,
  parameter int DIV_SLOW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              irq_hv_raw,
  input  logic              rst_hv_raw,
  input  logic              strap_raw,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mode_valid,
  output logic              monitor_mode,
  output logic              div_half,
  output logic              bus_ce,
  output logic              wdog_disable,
  output logic              mon_serial_en
);
  logic       rst_any;
  logic [2:0] pins_s;

  assign rst_any = rst | por;

  bm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst_any),
    .d   ({irq_hv_raw, rst_hv_raw, strap_raw}),
    .q   (pins_s)
  );

  bm_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eval (
    .clk           (clk),
    .rst_any       (rst_any),
    .por           (por),
    .irq_hv        (pins_s[2]),
    .rst_hv        (pins_s[1]),
    .strap         (pins_s[0]),
    .mem_rd_en     (mem_rd_en),
    .mem_addr      (mem_addr),
    .mem_rd_data   (mem_rd_data),
    .mode_valid    (mode_valid),
    .monitor_mode  (monitor_mode),
    .div_half      (div_half),
    .wdog_disable  (wdog_disable),
    .mon_serial_en (mon_serial_en)
  );

  bm_ce_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk  (clk),
    .rst  (rst_any),
    .half (div_half),
    .ce   (bus_ce)
  );

  // R6: serial link follows monitor mode
  p_serial_mon_r6: assert property (@(posedge clk) disable iff (rst_any)
    mon_serial_en |-> monitor_mode);
endmodule

// File: tb/tb_boot_mode_sel.sv
`timescale 1ns/1ps
module tb_boot_mode_sel;
  logic clk = 1'b0;
  logic rst, por, irq_hv_raw, rst_hv_raw, strap_raw;
  logic mem_rd_en, mode_valid, monitor_mode, div_half, bus_ce, wdog_disable, mon_serial_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rd_data;
  logic [7:0]  vec_lo, vec_hi;
  logic        clr_log;
  logic [15:0] rd_log [4];
  int          rd_cnt;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  boot_mode_sel dut (
    .clk(clk), .rst(rst), .por(por), .irq_hv_raw(irq_hv_raw), .rst_hv_raw(rst_hv_raw),
    .strap_raw(strap_raw), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .mode_valid(mode_valid), .monitor_mode(monitor_mode),
    .div_half(div_half), .bus_ce(bus_ce), .wdog_disable(wdog_disable),
    .mon_serial_en(mon_serial_en)
  );

  // memory model with one-cycle read latency and a read log
  always @(posedge clk) begin
    if (clr_log) rd_cnt <= 0;
    else if (mem_rd_en) begin
      mem_rd_data <= (mem_addr == 16'hFFFE) ? vec_lo :
                     (mem_addr == 16'hFFFF) ? vec_hi : 8'h00;
      if (rd_cnt < 4) rd_log[rd_cnt] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // apply a reset and return edges from release until mode_valid
  task automatic do_reset(input bit power, output int lat);
    @(negedge clk);
    por = power; rst = 1'b1; clr_log = 1'b1;
    cyc(3);
    rst = 1'b0; por = 1'b0; clr_log = 1'b0;
    lat = 0;
    while (!mode_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic boot(input bit ih, input bit rh, input bit st,
                      input logic [7:0] lo, input logic [7:0] hi, output int lat);
    irq_hv_raw = ih; rst_hv_raw = rh; strap_raw = st; vec_lo = lo; vec_hi = hi;
    do_reset(1'b1, lat);
  endtask

  task automatic ce_period(output int p);
    int w;
    w = 0;
    while (!bus_ce && w < 10) begin @(negedge clk); w++; end
    @(negedge clk);
    p = 1;
    while (!bus_ce && p < 10) begin @(negedge clk); p++; end
  endtask

  task automatic expect_mode(input string req, input int mon, input int half,
                             input int wd, input int ser);
    chk({req, " monitor_mode"}, monitor_mode, mon);
    chk({req, " div_half"}, div_half, half);
    chk({req, " wdog_disable"}, wdog_disable, wd);
    chk({req, " mon_serial_en"}, mon_serial_en, ser);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    por = 1'b1; rst = 1'b1; clr_log = 1'b1;
    cyc(3);
    chk("R11 mode_valid", mode_valid, 0);
    chk("R11 mem_rd_en", mem_rd_en, 0);
    chk("R11 bus_ce", bus_ce, 0);
    expect_mode("R11", 0, 0, 0, 0);
  endtask

  task automatic t_hv_strap_low();
    int lat, p;
    boot(1, 0, 0, 8'h00, 8'h00, lat);
    chk("R1 latency", lat, 4);
    chk("R1 read count", rd_cnt, 2);
    chk("R1 first addr", rd_log[0], 16'hFFFE);
    chk("R1 second addr", rd_log[1], 16'hFFFF);
    expect_mode("R2", 1, 1, 1, 1);
    ce_period(p); ce_period(p);
    chk("R8 fast period", p, 2);
    strap_raw = 1'b1; irq_hv_raw = 1'b0; rst_hv_raw = 1'b1;
    cyc(6);
    chk("R9 div_half held", div_half, 1);
    chk("R9 monitor held", monitor_mode, 1);
  endtask

  task automatic t_hv_strap_high();
    int lat, p;
    boot(1, 0, 1, 8'hFF, 8'hFF, lat);
    chk("R3 latency", lat, 4);
    expect_mode("R3", 1, 0, 1, 1);
    ce_period(p); ce_period(p);
    chk("R8 slow period", p, 4);
  endtask

  task automatic t_blank();
    int lat;
    boot(0, 0, 1, 8'hFF, 8'hFF, lat);
    expect_mode("R4 strap high", 1, 0, 1, 1);
    boot(0, 0, 0, 8'hFF, 8'hFF, lat);
    expect_mode("R4 strap low", 1, 0, 1, 1);
    cyc(6);
    chk("R6 blank path wdog held", wdog_disable, 1);
  endtask

  task automatic t_user();
    int lat, p;
    boot(0, 0, 0, 8'hFF, 8'h12, lat);
    chk("R5 latency", lat, 4);
    expect_mode("R5 hi byte set", 0, 0, 0, 0);
    ce_period(p); ce_period(p);
    chk("R8 user period", p, 4);
    boot(0, 0, 1, 8'h34, 8'hFF, lat);
    expect_mode("R5 lo byte set", 0, 0, 0, 0);
  endtask

  task automatic t_wdog_live();
    int lat;
    boot(1, 1, 0, 8'h00, 8'h00, lat);
    expect_mode("R7 entry", 1, 1, 1, 1);
    irq_hv_raw = 1'b0;
    cyc(4);
    chk("R7 reset pin keeps wdog", wdog_disable, 1);
    rst_hv_raw = 1'b0;
    cyc(4);
    chk("R7 wdog drops", wdog_disable, 0);
    chk("R7 still monitor", monitor_mode, 1);
    chk("R9 ratio kept", div_half, 1);
    irq_hv_raw = 1'b1;
    cyc(4);
    chk("R7 wdog returns", wdog_disable, 1);
  endtask

  task automatic t_warm();
    int lat;
    boot(0, 0, 0, 8'hFF, 8'hFF, lat);
    expect_mode("R10 before", 1, 0, 1, 1);
    vec_hi = 8'h00; strap_raw = 1'b1;
    do_reset(1'b0, lat);
    chk("R10 warm latency", lat, 1);
    chk("R10 no reads", rd_cnt, 0);
    expect_mode("R10 after warm", 1, 0, 1, 1);
    do_reset(1'b1, lat);
    chk("R10 por latency", lat, 4);
    expect_mode("R10 por re-eval", 0, 0, 0, 0);
  endtask

  initial begin
    rst = 1'b1; por = 1'b1; clr_log = 1'b1;
    irq_hv_raw = 1'b0; rst_hv_raw = 1'b0; strap_raw = 1'b0;
    vec_lo = 8'hFF; vec_hi = 8'hFF; mem_rd_data = 8'h00;
    t_reset_state();
    t_hv_strap_low();
    t_hv_strap_high();
    t_blank();
    t_user();
    t_wdog_live();
    t_warm();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule